// File: doc/BRIEF.md
# Sampled Value Change Detector

This block watches a bus of single-bit signals and reports, for every sampling edge of its clock, whether each bit rose, fell, held or changed with respect to the value it had at the previous sampling edge. Each channel is handled on its own. The block also tracks an unknown state for every bit. The hardware is two-state, so the unknown condition reaches the block on a separate per-bit qualifier. When the qualifier is low, the bit counts as unknown and its data value has no effect.

Each sample is mapped to a two-bit code. Known 0 maps to `00`, known 1 to `11` and unknown to `01`. Bit 0 of the code is set when the sample is not exactly 0. Bit 1 is set only when the sample is exactly 1. That code is stored at every sampling edge, and "stable" means the live code matches the stored one. Rise and fall detection each use their own one-bit history of "exactly 1" and "exactly 0". All history registers start from power-up values and have no reset, so the first edge behaves as if the earlier sample were unknown.

The flags are combinational. They describe the cycle that ends at the next sampling edge, and a parameter picks whether that edge is the rising or the falling edge of the clock.

Top module: `sampled_change_mon`

## Requirements
- R1: Each sample maps to a code where known 0 is `00`, known 1 is `11` and unknown is `01`. A sample is unknown when its `sig_known` bit is 0, and its `sig_val` bit is then ignored.
- R2: The stored code powers up as `01`, so a channel that is unknown before the first sampling edge reports stable and not changed.
- R3: `stable_o` is high exactly when the live code equals the code stored at the previous sampling edge, and `changed_o` is always its complement. Unknown followed by unknown is therefore stable.
- R4: `rose_o` is high when the sample is exactly 1 and the previous sample was not exactly 1. A previous sample that was unknown, or that does not exist yet after power-up, counts as not exactly 1.
- R5: `fell_o` is high when the sample is exactly 0 and the previous sample was not exactly 0. A previous sample that was unknown, or that does not exist yet after power-up, counts as not exactly 0.
- R6: Before the first sampling edge, a known 1 reports rose and changed, and a known 0 reports fell and changed.
- R7: A move from a known value to unknown reports changed, with neither rose nor fell.
- R8: Rose and fell are never high together, and neither is high while stable is high.
- R9: Every channel of the bus is detected independently of the others.
- R10: With `RISE_EDGE` = 1 the history is captured on the rising clock edge. With `RISE_EDGE` = 0 it is captured on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the sampling edge is chosen by `RISE_EDGE` |
| sig_val | input | N_CH | Data value of each monitored bit |
| sig_known | input | N_CH | 1 when the matching bit is a known value, 0 when it is unknown |
| rose_o | output | N_CH | Per-channel rise flag |
| fell_o | output | N_CH | Per-channel fall flag |
| stable_o | output | N_CH | Per-channel no-change flag |
| changed_o | output | N_CH | Per-channel change flag |

## Verification
Four channels each run a different repeating sequence over 0, 1 and unknown. One channel cycles 0, 1, 0, unknown. Another cycles 1, 1, 0, 1, unknown, which separates a held 1 from a fresh rise. The other two place unknown next to unknown and next to both known values, which separates a code comparison from a plain XOR of the data bit. Unknown samples carry alternating data values, which shows that the qualifier overrides the data bit. The first vector checks power-up history against all three values. A second instance that samples on the falling edge is checked just before and just after a falling edge, which tells the two edge choices apart.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef logic [1:0] vcode_t;

  localparam vcode_t CODE_ZERO = 2'b00;
  localparam vcode_t CODE_ONE  = 2'b11;
  localparam vcode_t CODE_UNK  = 2'b01;

  // bit0: not exactly zero, bit1: exactly one
  function automatic vcode_t vc_encode(input logic val, input logic known);
    return {known & val, ~known | val};
  endfunction

  function automatic logic vc_exact1(input logic val, input logic known);
    return known & val;
  endfunction

  function automatic logic vc_exact0(input logic val, input logic known);
    return known & ~val;
  endfunction
endpackage

// File: rtl/vc_hist_reg.sv
module vc_hist_reg #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = INIT;

  always_ff @(posedge clk) begin
    q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/vc_channel.sv
module vc_channel
  import svc_pkg::*;
(
  input  logic smp_clk,
  input  logic val,
  input  logic known,
  output logic rose,
  output logic fell,
  output logic stable,
  output logic changed
);
  vcode_t cur_code;
  vcode_t past_code;
  logic   one_now, zero_now;
  logic   one_past, zero_past;

  assign cur_code = vc_encode(val, known);
  assign one_now  = vc_exact1(val, known);
  assign zero_now = vc_exact0(val, known);

  vc_hist_reg #(.W(2), .INIT(CODE_UNK)) u_code_hist (
    .clk(smp_clk), .d(cur_code), .q(past_code)
  );
  vc_hist_reg #(.W(1), .INIT(1'b0)) u_one_hist (
    .clk(smp_clk), .d(one_now), .q(one_past)
  );
  vc_hist_reg #(.W(1), .INIT(1'b0)) u_zero_hist (
    .clk(smp_clk), .d(zero_now), .q(zero_past)
  );

  assign stable  = (cur_code == past_code);
  assign changed = ~stable;
  assign rose    = one_now & ~one_past;
  assign fell    = zero_now & ~zero_past;

  // checker qualifier: high once one sampling edge has passed
  logic armed = 1'b0;
  always_ff @(posedge smp_clk) armed <= 1'b1;

  // R8
  rose_fell_excl_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    !(rose && fell));

  // R8
  stable_no_edge_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    stable |-> (!rose && !fell));

  // R4
  no_double_rise_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    rose |=> !rose);

  // R5
  no_double_fall_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    fell |=> !fell);

  // R7
  to_unknown_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    (!known && $past(known)) |-> (changed && !rose && !fell));

  // R4
  known_flip_chk: assert property (@(posedge smp_clk) disable iff (!armed)
    (known && $past(known) && (val != $past(val))) |-> (rose || fell));
endmodule

// File: rtl/sampled_change_mon.sv
module sampled_change_mon #(
  parameter int N_CH      = 4,
  parameter bit RISE_EDGE = 1'b1
) (
  input  logic            clk,
  input  logic [N_CH-1:0] sig_val,
  input  logic [N_CH-1:0] sig_known,
  output logic [N_CH-1:0] rose_o,
  output logic [N_CH-1:0] fell_o,
  output logic [N_CH-1:0] stable_o,
  output logic [N_CH-1:0] changed_o
);
  logic smp_clk;

  generate
    if (RISE_EDGE) begin : g_rise
      assign smp_clk = clk;
    end else begin : g_fall
      assign smp_clk = ~clk;
    end
  endgenerate

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      vc_channel u_ch (
        .smp_clk (smp_clk),
        .val     (sig_val[c]),
        .known   (sig_known[c]),
        .rose    (rose_o[c]),
        .fell    (fell_o[c]),
        .stable  (stable_o[c]),
        .changed (changed_o[c])
      );
    end
  endgenerate
endmodule

// File: tb/sampled_change_mon_tb.sv
`timescale 1ns/1ps
module sampled_change_mon_tb;
  localparam int N_CH  = 4;
  localparam int STEPS = 12;
  // per channel 2 bits: 0 = known 0, 1 = known 1, 2 = unknown; {ch3,ch2,ch1,ch0}
  localparam logic [7:0] STIM [STEPS] = '{
    8'h64, 8'hA5, 8'h40, 8'h66, 8'h18, 8'h25,
    8'hA4, 8'h82, 8'h44, 8'h19, 8'h94, 8'h26
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N_CH-1:0] sig_val = '0, sig_known = '0;
  logic [N_CH-1:0] rose_o, fell_o, stable_o, changed_o;
  logic [0:0] n_val = 1'b0, n_known = 1'b1;
  logic [0:0] n_rose, n_fell, n_stable, n_changed;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  sampled_change_mon #(.N_CH(N_CH), .RISE_EDGE(1'b1)) u_dut (
    .clk(clk), .sig_val(sig_val), .sig_known(sig_known),
    .rose_o(rose_o), .fell_o(fell_o), .stable_o(stable_o), .changed_o(changed_o)
  );

  sampled_change_mon #(.N_CH(1), .RISE_EDGE(1'b0)) u_dut_neg (
    .clk(clk), .sig_val(n_val), .sig_known(n_known),
    .rose_o(n_rose), .fell_o(n_fell), .stable_o(n_stable), .changed_o(n_changed)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] vec, input int step);
    for (int c = 0; c < N_CH; c++) begin
      logic [1:0] v;
      v = vec[2*c +: 2];
      sig_known[c] = (v != 2'd2);
      // unknown samples carry alternating data to show the data bit is ignored (R1)
      sig_val[c]   = (v == 2'd2) ? step[0] : (v == 2'd1);
    end
  endtask

  initial begin
    int prev [N_CH];
    for (int c = 0; c < N_CH; c++) prev[c] = 2;  // model: no past = unknown (R2)
    apply(STIM[0], 0);
    #2;
    for (int s = 0; s < STEPS; s++) begin
      if (s > 0) begin
        @(posedge clk);
        #1 apply(STIM[s], s);
        #3;
      end
      for (int c = 0; c < N_CH; c++) begin
        int cur;
        logic e_rose, e_fell, e_stab;
        string tag;
        cur = int'(STIM[s][2*c +: 2]);
        e_rose = (cur == 1) && (prev[c] != 1);
        e_fell = (cur == 0) && (prev[c] != 0);
        e_stab = (cur == prev[c]);
        tag = $sformatf("step %0d ch %0d (R9)", s, c);
        if (s == 0) tag = {tag, " first edge R2 R6"};
        if (cur == 2 && prev[c] != 2) tag = {tag, " R7"};
        chk(rose_o[c],    e_rose,  {"R4 rose ", tag});
        chk(fell_o[c],    e_fell,  {"R5 fell ", tag});
        chk(stable_o[c],  e_stab,  {"R1 R3 stable ", tag});
        chk(changed_o[c], !e_stab, {"R3 changed ", tag});
        chk(!((rose_o[c] && fell_o[c]) || (stable_o[c] && (rose_o[c] || fell_o[c]))),
            1'b1, {"R8 exclusive ", tag});
        prev[c] = cur;
      end
    end

    // R1: unknown with data 1 then unknown with data 0 stays stable
    @(posedge clk);
    #1 sig_known = '0; sig_val = '1;
    @(posedge clk);
    #1 sig_val = '0;
    #3 chk(stable_o[0], 1'b1, "R1 unknown data ignored stable");
    chk(rose_o[0] | fell_o[0], 1'b0, "R1 unknown data ignored no edge");

    // R10: falling-edge instance, input held at known 0 so far
    @(posedge clk);
    #1 n_val = 1'b1;
    #1 chk(n_rose[0], 1'b1, "R10 rose before falling edge");
    chk(n_changed[0], 1'b1, "R10 changed before falling edge");
    @(negedge clk);
    #1 chk(n_rose[0], 1'b0, "R10 history taken at falling edge");
    chk(n_stable[0], 1'b1, "R10 stable after falling edge");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule